// File: doc/BRIEF.md
# Reversible-Gate Programmable Logic Array

This block is a sum-of-products logic array with a parameterised number of inputs, product terms and outputs. All datapath logic is made from two reversible primitives. One is a two-line copy gate that passes A and returns A XOR B. The other is a three-line conservative selector gate with outputs A, A^B^C and (~A&C)^(A&B). An AND is that selector gate with its third input held at 0. An OR is the same gate with its second input held at 1. A signal that feeds several gate inputs is copied through a chain of copy gates with a 0 on the second line; no net feeds two gate inputs. Gate outputs that carry no result are collected on a garbage bus.

Configuration is loaded one row at a time through a write port into a shadow store. A commit strobe moves the whole shadow into the active store, so the array never evaluates a partly written setup. A mode parameter selects a programmable OR plane, or a fixed OR plane in which each output owns a contiguous group of product terms. The reset input asserts asynchronously and is released through a two-flop synchroniser, so writes and commits take effect from the third rising edge after release.

Top module: `rpla_top`

## Requirements
- R1: A product-term row holds a 2-bit code per input, with input i at bits [2i+1:2i]. Code 00 leaves input i out, 01 uses it true, 10 uses it inverted, and 11 forces the term to 0. A row of all 00 gives a constant 1.
- R2: With PAL_MODE=0, output m equals the OR of every term t whose bit t is set in output row m, XORed with bit N_TERM of that row (the invert bit). No enabled term gives 0 before the invert.
- R3: With PAL_MODE=1, output m ORs terms m*GRP to m*GRP+GRP-1, where GRP = N_TERM/N_OUT. The term-enable bits of output rows have no effect, and the invert bit still applies.
- R4: Addresses 0 to N_TERM-1 select product-term rows, and addresses N_TERM to N_TERM+N_OUT-1 select output rows. A write to any higher address changes nothing.
- R5: A write changes only the shadow store, and the outputs keep following the previous active setup. After the edge that samples cfg_commit, the outputs follow the whole shadow.
- R6: When cfg_we and cfg_commit are sampled on the same edge, the commit takes the shadow as it stood before that write. The write stays in the shadow for the next commit.
- R7: After reset every stored bit is 0. Outputs are then all 0 with PAL_MODE=0 and all 1 with PAL_MODE=1.
- R8: The outputs depend combinationally on x_i and show a new input vector in the same cycle.
- R9: garbage_count equals 5*N*P + 4*P*M + M for PAL_MODE=0 and 5*N*P + 2*P + M for PAL_MODE=1. ancilla_count equals 2*N*P - N + 3*P*M + M and 2*N*P - N + 2*P + M for the same modes (N inputs, P terms, M outputs).
- R10: The garbage_o bus is exactly garbage_count bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| cfg_we | input | 1 | Write one row into the shadow store |
| cfg_addr | input | AW = clog2(N_TERM+N_OUT) | Row address |
| cfg_wdata | input | max(2*N_IN, N_TERM+1) | Row contents |
| cfg_commit | input | 1 | Copy the shadow store into the active store |
| x_i | input | N_IN | Logic inputs |
| y_o | output | N_OUT | Logic outputs |
| garbage_o | output | garbage_count | Unused gate outputs |
| garbage_count | output | 32 | Number of garbage lines (constant) |
| ancilla_count | output | 32 | Number of constant gate inputs (constant) |

## Verification
The outputs have no register stage, so a new input vector is checked 1 ns after it is driven, inside the same clock cycle. Row writes and commits are driven on a falling edge, sampled on the next rising edge, and reach the outputs right after that edge. Each check therefore runs after the following falling edge and steps through all input vectors, one per cycle. Shadow-only writes are checked in the cycles between the write and the commit, to confirm that the outputs still match the old setup. Both modes run on the same stimulus so the fixed and programmable OR planes are compared side by side.

// File: rtl/rpla_pkg.sv
package rpla_pkg;

  function automatic int garbage_lines(input int n, input int p, input int m, input bit pal);
    if (pal) return 5 * n * p + 2 * p + m;
    return 5 * n * p + 4 * p * m + m;
  endfunction

  function automatic int ancilla_lines(input int n, input int p, input int m, input bit pal);
    if (pal) return 2 * n * p - n + 2 * p + m;
    return 2 * n * p - n + 3 * p * m + m;
  endfunction

  localparam logic [1:0] LIT_SKIP = 2'b00;
  localparam logic [1:0] LIT_TRUE = 2'b01;
  localparam logic [1:0] LIT_INV  = 2'b10;
  localparam logic [1:0] LIT_KILL = 2'b11;

endpackage

// File: rtl/rpla_cnot.sv
module rpla_cnot (
  input  logic a_i,
  input  logic b_i,
  output logic p_o,
  output logic q_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
endmodule

// File: rtl/rpla_mux3.sv
module rpla_mux3 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i ^ c_i;
  assign r_o = (~a_i & c_i) ^ (a_i & b_i);
endmodule

// File: rtl/rpla_fanout.sv
// Produces K copies of one line through a chain of copy gates.
module rpla_fanout #(
  parameter int K = 2
) (
  input  logic         x_i,
  output logic [K-1:0] y_o
);
  logic [K-1:0] link;
  assign link[0] = x_i;

  for (genvar i = 0; i < K - 1; i++) begin : g_copy
    rpla_cnot u_cp (
      .a_i (link[i]),
      .b_i (1'b0),
      .p_o (link[i+1]),
      .q_o (y_o[i])
    );
  end

  assign y_o[K-1] = link[K-1];
endmodule

// File: rtl/rpla_chain.sv
// Linear AND or OR reduction built from selector gates.
module rpla_chain #(
  parameter int W     = 4,
  parameter bit IS_OR = 1'b0
) (
  input  logic [W-1:0]   v_i,
  output logic           y_o,
  output logic [2*W-1:0] garb_o
);
  logic [W:0] acc;

  if (IS_OR) begin : g_seed_or
    assign acc[0] = 1'b0;
  end else begin : g_seed_and
    assign acc[0] = 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (IS_OR) begin : g_or
      rpla_mux3 u_g (
        .a_i (v_i[i]),
        .b_i (1'b1),
        .c_i (acc[i]),
        .p_o (garb_o[2*i]),
        .q_o (garb_o[2*i+1]),
        .r_o (acc[i+1])
      );
    end else begin : g_and
      rpla_mux3 u_g (
        .a_i (v_i[i]),
        .b_i (acc[i]),
        .c_i (1'b0),
        .p_o (garb_o[2*i]),
        .q_o (garb_o[2*i+1]),
        .r_o (acc[i+1])
      );
    end
  end

  assign y_o = acc[W];
endmodule

// File: rtl/rpla_term.sv
// One product term: per-input literal stage followed by an AND chain.
module rpla_term #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0]   x_i,
  input  logic [2*N_IN-1:0] sel_i,
  output logic              y_o,
  output logic [5*N_IN-1:0] garb_o
);
  localparam int LG = 3 * N_IN;

  logic [N_IN-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    logic [1:0] code;
    logic       use_x, flip, idle_val, xs;
    assign code     = sel_i[2*i +: 2];
    assign use_x    = code[0] ^ code[1];
    assign flip     = code[1];
    assign idle_val = (code == rpla_pkg::LIT_SKIP);

    rpla_cnot u_pol (
      .a_i (flip),
      .b_i (x_i[i]),
      .p_o (garb_o[3*i]),
      .q_o (xs)
    );

    rpla_mux3 u_pick (
      .a_i (use_x),
      .b_i (xs),
      .c_i (idle_val),
      .p_o (garb_o[3*i+1]),
      .q_o (garb_o[3*i+2]),
      .r_o (lit[i])
    );
  end

  rpla_chain #(.W(N_IN), .IS_OR(1'b0)) u_and (
    .v_i    (lit),
    .y_o    (y_o),
    .garb_o (garb_o[LG +: 2*N_IN])
  );
endmodule

// File: rtl/rpla_cfg.sv
// Shadow and active configuration stores with reset synchroniser.
module rpla_cfg #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter int AW     = 4,
  parameter int ROWW   = 9
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [ROWW-1:0]                    wdata_i,
  input  logic                               commit_i,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_act_o,
  output logic [N_OUT-1:0][N_TERM:0]         or_act_o
);
  localparam int SELW = 2 * N_IN;

  logic rs_q1, rs_q2, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s_n = rs_q2;

  logic [N_TERM-1:0][SELW-1:0] and_sh_q, and_sh_d, and_act_q;
  logic [N_OUT-1:0][N_TERM:0]  or_sh_q, or_sh_d, or_act_q;
  logic                        sh_en, act_en;

  assign sh_en  = we_i;
  assign act_en = commit_i;

  always_comb begin
    and_sh_d = and_sh_q;
    or_sh_d  = or_sh_q;
    for (int t = 0; t < N_TERM; t++) begin
      if (addr_i == AW'(t)) and_sh_d[t] = wdata_i[SELW-1:0];
    end
    for (int m = 0; m < N_OUT; m++) begin
      if (addr_i == AW'(N_TERM + m)) or_sh_d[m] = wdata_i[N_TERM:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      and_sh_q <= '0;
      or_sh_q  <= '0;
    end else if (sh_en) begin
      and_sh_q <= and_sh_d;
      or_sh_q  <= or_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      and_act_q <= '0;
      or_act_q  <= '0;
    end else if (act_en) begin
      and_act_q <= and_sh_q;
      or_act_q  <= or_sh_q;
    end
  end

  assign and_act_o = and_act_q;
  assign or_act_o  = or_act_q;
endmodule

// File: rtl/rpla_top.sv
module rpla_top #(
  parameter int N_IN     = 4,
  parameter int N_TERM   = 8,
  parameter int N_OUT    = 4,
  parameter bit PAL_MODE = 1'b0,
  localparam int SELW    = 2 * N_IN,
  localparam int ROWW    = (SELW > N_TERM + 1) ? SELW : N_TERM + 1,
  localparam int ROWS    = N_TERM + N_OUT,
  localparam int AW      = (ROWS > 2) ? $clog2(ROWS) : 1,
  localparam int GARB    = rpla_pkg::garbage_lines(N_IN, N_TERM, N_OUT, PAL_MODE),
  localparam int ANC     = rpla_pkg::ancilla_lines(N_IN, N_TERM, N_OUT, PAL_MODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [ROWW-1:0]   cfg_wdata,
  input  logic              cfg_commit,
  input  logic [N_IN-1:0]   x_i,
  output logic [N_OUT-1:0]  y_o,
  output logic [GARB-1:0]   garbage_o,
  output logic [31:0]       garbage_count,
  output logic [31:0]       ancilla_count
);
  localparam int GRP      = N_TERM / N_OUT;
  localparam int TG       = 5 * N_IN;
  localparam int TERM_END = TG * N_TERM;

  assign garbage_count = 32'(GARB);
  assign ancilla_count = 32'(ANC);

  logic [N_TERM-1:0][SELW-1:0] and_act;
  logic [N_OUT-1:0][N_TERM:0]  or_act;

  rpla_cfg #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .ROWW(ROWW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr),
    .wdata_i   (cfg_wdata),
    .commit_i  (cfg_commit),
    .and_act_o (and_act),
    .or_act_o  (or_act)
  );

  // Input copies: one per product term.
  logic [N_TERM-1:0] xin_cp [N_IN];
  logic [N_IN-1:0]   term_x [N_TERM];
  logic [N_TERM-1:0] term_v;

  for (genvar i = 0; i < N_IN; i++) begin : g_xfan
    rpla_fanout #(.K(N_TERM)) u_fan (
      .x_i (x_i[i]),
      .y_o (xin_cp[i])
    );
    for (genvar t = 0; t < N_TERM; t++) begin : g_route
      assign term_x[t][i] = xin_cp[i][t];
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    rpla_term #(.N_IN(N_IN)) u_term (
      .x_i    (term_x[t]),
      .sel_i  (and_act[t]),
      .y_o    (term_v[t]),
      .garb_o (garbage_o[t*TG +: TG])
    );
  end

  if (PAL_MODE) begin : g_fixed_or
    localparam int OW = 2 * GRP + 1;
    for (genvar m = 0; m < N_OUT; m++) begin : g_out
      logic or_v;
      rpla_chain #(.W(GRP), .IS_OR(1'b1)) u_or (
        .v_i    (term_v[m*GRP +: GRP]),
        .y_o    (or_v),
        .garb_o (garbage_o[TERM_END + m*OW +: 2*GRP])
      );
      rpla_cnot u_inv (
        .a_i (or_act[m][N_TERM]),
        .b_i (or_v),
        .p_o (garbage_o[TERM_END + m*OW + 2*GRP]),
        .q_o (y_o[m])
      );
    end
  end else begin : g_prog_or
    localparam int SEL_BASE = TERM_END;
    localparam int CH_BASE  = TERM_END + 2 * N_TERM * N_OUT;
    localparam int OW       = 2 * N_TERM + 1;

    logic [N_OUT-1:0]  term_cp [N_TERM];
    logic [N_TERM-1:0] gated   [N_OUT];

    for (genvar t = 0; t < N_TERM; t++) begin : g_tfan
      rpla_fanout #(.K(N_OUT)) u_fan (
        .x_i (term_v[t]),
        .y_o (term_cp[t])
      );
    end

    for (genvar m = 0; m < N_OUT; m++) begin : g_out
      logic or_v;
      for (genvar t = 0; t < N_TERM; t++) begin : g_gate
        rpla_mux3 u_en (
          .a_i (or_act[m][t]),
          .b_i (term_cp[t][m]),
          .c_i (1'b0),
          .p_o (garbage_o[SEL_BASE + 2*(m*N_TERM + t)]),
          .q_o (garbage_o[SEL_BASE + 2*(m*N_TERM + t) + 1]),
          .r_o (gated[m][t])
        );
      end
      rpla_chain #(.W(N_TERM), .IS_OR(1'b1)) u_or (
        .v_i    (gated[m]),
        .y_o    (or_v),
        .garb_o (garbage_o[CH_BASE + m*OW +: 2*N_TERM])
      );
      rpla_cnot u_inv (
        .a_i (or_act[m][N_TERM]),
        .b_i (or_v),
        .p_o (garbage_o[CH_BASE + m*OW + 2*N_TERM]),
        .q_o (y_o[m])
      );
    end
  end
endmodule

// File: rtl/rpla_chk.sv
module rpla_chk #(
  parameter int N_IN     = 4,
  parameter int N_TERM   = 8,
  parameter int N_OUT    = 4,
  parameter bit PAL_MODE = 1'b0,
  localparam int GARB    = rpla_pkg::garbage_lines(N_IN, N_TERM, N_OUT, PAL_MODE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_commit,
  input logic [N_IN-1:0]   x_i,
  input logic [N_OUT-1:0]  y_o,
  input logic [GARB-1:0]   garbage_o
);
  localparam logic [N_OUT-1:0] RST_Y = PAL_MODE ? '1 : '0;

  logic seen_q, dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (cfg_commit) seen_q <= 1'b1;
      if (cfg_we) dirty_q <= 1'b1;
      else if (cfg_commit) dirty_q <= 1'b0;
    end
  end

  // R7: before any commit the outputs hold the reset pattern
  p_reset_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (y_o == RST_Y));

  // R5: without a commit on the previous edge, a steady input gives a steady output
  p_hold_until_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_commit) && $stable(x_i)) |-> $stable(y_o));

  // R5: a commit with no write since the previous commit changes nothing
  p_idle_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_commit && !dirty_q) |=> (!$stable(x_i) || $stable(y_o)));

  // R10: garbage lines settle with the configuration and inputs
  p_garbage_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_commit) && $stable(x_i)) |-> $stable(garbage_o));
endmodule

bind rpla_top rpla_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(PAL_MODE)
) u_chk (.*);

// File: tb/tb_rpla_top.sv
module tb_rpla_top;
  localparam int NI   = 4;
  localparam int NT   = 8;
  localparam int NO   = 4;
  localparam int GRP  = NT / NO;
  localparam int SELW = 2 * NI;
  localparam int ROWW = (SELW > NT + 1) ? SELW : NT + 1;
  localparam int AW   = 4;
  localparam int GP   = 292;
  localparam int GL   = 180;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [ROWW-1:0] cfg_wdata = '0;
  logic            cfg_commit = 1'b0;
  logic [NI-1:0]   x = '0;

  logic [NO-1:0] y_pla, y_pal;
  logic [GP-1:0] g_pla;
  logic [GL-1:0] g_pal;
  logic [31:0]   gc_pla, ac_pla, gc_pal, ac_pal;

  always #10 clk = ~clk;

  rpla_top #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .PAL_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .x_i(x), .y_o(y_pla),
    .garbage_o(g_pla), .garbage_count(gc_pla), .ancilla_count(ac_pla)
  );

  rpla_top #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .PAL_MODE(1'b1)) dut_pal (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .x_i(x), .y_o(y_pal),
    .garbage_o(g_pal), .garbage_count(gc_pal), .ancilla_count(ac_pal)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit [SELW-1:0] sh_t  [NT];
  bit [SELW-1:0] act_t [NT];
  bit [NT:0]     sh_o  [NO];
  bit [NT:0]     act_o [NO];

  function automatic bit [NO-1:0] model(input bit [NI-1:0] xv, input bit pal);
    bit [NT-1:0] tv;
    bit [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      bit v = 1'b1;
      for (int i = 0; i < NI; i++) begin
        case (act_t[t][2*i +: 2])
          2'b01: v = v & xv[i];
          2'b10: v = v & ~xv[i];
          2'b11: v = 1'b0;
          default: ;
        endcase
      end
      tv[t] = v;
    end
    for (int m = 0; m < NO; m++) begin
      bit acc = 1'b0;
      for (int t = 0; t < NT; t++) begin
        if (pal ? (t / GRP == m) : act_o[m][t]) acc = acc | tv[t];
      end
      r[m] = acc ^ act_o[m][NT];
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      x = NI'(v);
      #1;
      check(req, $sformatf("pla x=%0h", v), 32'(y_pla), 32'(model(NI'(v), 1'b0)));
      check(req, $sformatf("pal x=%0h", v), 32'(y_pal), 32'(model(NI'(v), 1'b1)));
    end
  endtask

  task automatic put_row(input int a, input logic [ROWW-1:0] d);
    if (a < NT) sh_t[a] = d[SELW-1:0];
    else if (a < NT + NO) sh_o[a-NT] = d[NT:0];
  endtask

  task automatic take_commit();
    for (int t = 0; t < NT; t++) act_t[t] = sh_t[t];
    for (int m = 0; m < NO; m++) act_o[m] = sh_o[m];
  endtask

  task automatic wr(input int a, input logic [ROWW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    put_row(a, d);
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    take_commit();
  endtask

  task automatic t_reset();
    for (int t = 0; t < NT; t++) begin sh_t[t] = '0; act_t[t] = '0; end
    for (int m = 0; m < NO; m++) begin sh_o[m] = '0; act_o[m] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7 reset pattern, R8 same-cycle response
    check_all("R7 R8");
  endtask

  task automatic t_literals();
    wr(0, ROWW'(9'h009));
    wr(1, ROWW'(9'h010));
    wr(2, ROWW'(9'h0C1));
    wr(NT + 0, 9'h001);
    wr(NT + 1, 9'h006);
    wr(NT + 2, 9'h100);
    wr(NT + 3, 9'h103);
    commit();
    // R1 literal codes incl. kill, R2 programmable OR with invert, R3 fixed groups
    check_all("R1 R2 R3");
  endtask

  task automatic t_shadow();
    wr(0, ROWW'(9'h002));
    wr(NT + 2, 9'h0FF);
    // R5 outputs still follow previous active setup
    check_all("R5");
    commit();
    check_all("R5");
  endtask

  task automatic t_commit_with_write();
    wr(3, ROWW'(9'h044));
    @(negedge clk);
    cfg_we = 1'b1; cfg_commit = 1'b1; cfg_addr = AW'(NT + 1); cfg_wdata = 9'h108;
    @(negedge clk);
    cfg_we = 1'b0; cfg_commit = 1'b0;
    take_commit();
    put_row(NT + 1, 9'h108);
    // R6 commit takes shadow before the same-edge write
    check_all("R6");
    commit();
    check_all("R6");
  endtask

  task automatic t_bad_addr();
    for (int a = NT + NO; a < (1 << AW); a++) wr(a, '1);
    commit();
    // R4 out-of-range addresses leave everything unchanged
    check_all("R4");
  endtask

  task automatic t_random();
    for (int round = 0; round < 6; round++) begin
      for (int t = 0; t < NT; t++) wr(t, ROWW'($urandom));
      for (int m = 0; m < NO; m++) wr(NT + m, ROWW'($urandom));
      commit();
      check_all("R1 R2 R3");
    end
  endtask

  task automatic t_counts();
    check("R9", "pla garbage_count", gc_pla, 32'(5*NI*NT + 4*NT*NO + NO));
    check("R9", "pla ancilla_count", ac_pla, 32'(2*NI*NT - NI + 3*NT*NO + NO));
    check("R9", "pal garbage_count", gc_pal, 32'(5*NI*NT + 2*NT + NO));
    check("R9", "pal ancilla_count", ac_pal, 32'(2*NI*NT - NI + 2*NT + NO));
    check("R10", "pla garbage width", 32'($bits(g_pla)), gc_pla);
    check("R10", "pal garbage width", 32'($bits(g_pal)), gc_pal);
  endtask

  initial begin
    t_reset();
    t_counts();
    t_literals();
    t_shadow();
    t_commit_with_write();
    t_bad_addr();
    t_random();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule